// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM with Per-Lane Parity

This block models a clocked single-port static memory that sits on a shared bidirectional data bus. Every cycle is opened by an active-low address strobe. While that strobe is low, the chip enable decides between loading a new address and deselecting the device. While the strobe is high, the previously loaded address is used again and chip enable plays no part. The byte-write strobes decide whether a cycle reads or writes. Each byte lane has one parity bit alongside it. The parity bit is stored and returned exactly like data and is never computed or checked.

The output enable works outside the clock. Raising it releases the data and parity pins at once, and the device drives the bus only in a read cycle with output enable low. The control is a three-state machine with the states `SB_DESEL`, `SB_READ` and `SB_WRITE`. The transitions are:
- `load-read`: strobe low, enable low, no write strobe low. Goes to `SB_READ`.
- `load-write`: strobe low, enable low, at least one write strobe low. Goes to `SB_WRITE`.
- `deselect`: strobe low, enable high. Goes to `SB_DESEL` from any state.
- `continue-read` and `continue-write`: strobe high while in `SB_READ` or `SB_WRITE`. The next state is picked by the write strobes.
- `stay-idle`: strobe high while in `SB_DESEL`. Remains in `SB_DESEL`.

Top module: `sync_bw_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, the state is `SB_DESEL` and neither `dq` nor `dp` is driven.
- R2: A rising clock edge with `ads_n`=0 and `ce_n`=1 deselects the device. After that edge no write takes place and the bus is not driven.
- R3: A rising edge with `ads_n`=0, `ce_n`=0 and `bw_n` all ones loads `addr` and starts a read. After that edge the device drives the word stored at `addr`, provided `oe_n` is low.
- R4: A rising edge with `ads_n`=0, `ce_n`=0 and any `bw_n` bit low loads `addr` and writes the bus value at that edge into the location `addr`.
- R5: On a rising edge with `ads_n`=1 after a read or a write, `ce_n` and `addr` are ignored. The held address is reused, for a write if any `bw_n` bit is low and for a read otherwise.
- R6: In `SB_DESEL`, edges with `ads_n`=1 leave the device deselected. Memory is not changed, even when write strobes are low.
- R7: Bit i of `bw_n` (0 = write) updates only data lane `dq[8i+7:8i]` and parity bit `dp[i]`. The other lanes of the location keep their contents.
- R8: The parity bit `dp[i]` is returned unchanged on a later read, together with its lane.
- R9: While `oe_n` is high, `dq` and `dp` are released at once, with no clock edge needed. Lowering `oe_n` in a read cycle drives them again at once.
- R10: During a write cycle the device never drives `dq` or `dp`, whatever the level of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for address, data and control |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | ADDR_W (19) | Address, loaded when a cycle starts with chip enable low |
| ads_n | input | 1 | Active-low address strobe that opens a cycle |
| ce_n | input | 1 | Active-low chip enable, sampled only with the strobe low |
| bw_n | input | LANES (8) | Active-low byte write strobes, bit i for lane i |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | LANES*LANE_W (64) | Bidirectional data bus |
| dp | inout | LANES (8) | Bidirectional parity bits, one per lane |

## Verification
A wrong control state shows up at the bus one clock edge after the cycle that caused it. A device left selected after a deselect either drives the bus on a later read-enabled edge or corrupts a location, and a later read of that location exposes the change. A wrong held address, or a write strobe routed to the wrong lane, appears as a mismatch in particular lanes on the first read after the fault. That is why the bench compares read data lane by lane against a shadow copy. A fault in output-enable gating is visible within the same cycle, because the bus has to release without waiting for a clock edge.

// File: rtl/sbw_pkg.sv
`timescale 1ns/1ps
package sbw_pkg;
    typedef enum logic [1:0] {
        SB_DESEL = 2'd0,
        SB_READ  = 2'd1,
        SB_WRITE = 2'd2
    } sbw_mode_e;
endpackage

// File: rtl/sbw_ctrl.sv
`timescale 1ns/1ps
module sbw_ctrl
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic              ce_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output sbw_mode_e         mode_q,
    output logic [ADDR_W-1:0] held_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              wr_go,
    output logic              rd_go
);
    sbw_mode_e mode_d;
    logic      load;
    logic      any_wr;

    // next-state decision
    always_comb begin
        any_wr = ~&bw_n;
        load   = !ads_n && !ce_n;
        mode_d = mode_q;
        unique case (mode_q)
            SB_DESEL: begin
                if (load) mode_d = any_wr ? SB_WRITE : SB_READ;
            end
            SB_READ, SB_WRITE: begin
                if (!ads_n && ce_n) mode_d = SB_DESEL;
                else                mode_d = any_wr ? SB_WRITE : SB_READ;
            end
            default: mode_d = SB_DESEL;
        endcase
    end

    // state register and held address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= SB_DESEL;
            held_addr <= '0;
        end else begin
            mode_q <= mode_d;
            if (load) held_addr <= addr;
        end
    end

    // outputs toward the array
    always_comb begin
        eff_addr = load ? addr : held_addr;
        wr_go    = (mode_d == SB_WRITE);
        rd_go    = (mode_d == SB_READ);
    end
endmodule

// File: rtl/sbw_array.sv
`timescale 1ns/1ps
module sbw_array #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       eff_addr,
    input  logic                    wr_go,
    input  logic                    rd_go,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        wpar,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        rpar
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] idx;
    assign idx = eff_addr[IDX_W-1:0];

    generate
        if (ADDR_W > IDX_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^eff_addr[ADDR_W-1:IDX_W];
        end
    endgenerate

    // one storage column per byte lane: parity bit on top of the data byte
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W:0] mem [DEPTH];
            logic [LANE_W:0] rd_q;

            always_ff @(posedge clk) begin
                if (wr_go && !bw_n[l])
                    mem[idx] <= {wpar[l], wdata[l*LANE_W +: LANE_W]};
                if (rd_go)
                    rd_q <= mem[idx];
            end

            assign rdata[l*LANE_W +: LANE_W] = rd_q[LANE_W-1:0];
            assign rpar[l]                   = rd_q[LANE_W];
        end
    endgenerate
endmodule

// File: rtl/sbw_bus.sv
`timescale 1ns/1ps
module sbw_bus
    import sbw_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  sbw_mode_e               mode_q,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] rdata,
    input  logic [LANES-1:0]        rpar,
    inout  wire  [LANES*LANE_W-1:0] dq,
    inout  wire  [LANES-1:0]        dp,
    output logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES-1:0]        wpar,
    output logic                    drv
);
    // output enable is not clocked: it gates the drivers directly
    assign drv   = (mode_q == SB_READ) && !oe_n;
    assign dq    = drv ? rdata : {(LANES*LANE_W){1'bz}};
    assign dp    = drv ? rpar  : {LANES{1'bz}};
    assign wdata = dq;
    assign wpar  = dp;
endmodule

// File: rtl/sync_bw_sram.sv
`timescale 1ns/1ps
module sync_bw_sram
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ads_n,
    input  logic                    ce_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    inout  wire  [LANES*LANE_W-1:0] dq,
    inout  wire  [LANES-1:0]        dp
);
    localparam int DW = LANES * LANE_W;

    sbw_mode_e         mode_q;
    logic [ADDR_W-1:0] held_addr;
    logic [ADDR_W-1:0] eff_addr;
    logic              wr_go;
    logic              rd_go;
    logic [DW-1:0]     rdata;
    logic [LANES-1:0]  rpar;
    logic [DW-1:0]     wdata;
    logic [LANES-1:0]  wpar;
    logic              bus_drv;

    sbw_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .ce_n(ce_n), .bw_n(bw_n),
        .addr(addr), .mode_q(mode_q), .held_addr(held_addr),
        .eff_addr(eff_addr), .wr_go(wr_go), .rd_go(rd_go)
    );

    sbw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_array (
        .clk(clk), .eff_addr(eff_addr), .wr_go(wr_go), .rd_go(rd_go),
        .bw_n(bw_n), .wdata(wdata), .wpar(wpar), .rdata(rdata), .rpar(rpar)
    );

    sbw_bus #(.LANES(LANES), .LANE_W(LANE_W)) u_bus (
        .mode_q(mode_q), .oe_n(oe_n), .rdata(rdata), .rpar(rpar),
        .dq(dq), .dp(dp), .wdata(wdata), .wpar(wpar), .drv(bus_drv)
    );
endmodule

// File: rtl/sbw_checker.sv
`timescale 1ns/1ps
module sbw_checker
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ads_n,
    input logic              ce_n,
    input logic [LANES-1:0]  bw_n,
    input logic              oe_n,
    input sbw_mode_e         mode_q,
    input logic [ADDR_W-1:0] held_addr,
    input logic              drv
);
    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == SB_DESEL && !drv));

    assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && ce_n) |=> (mode_q == SB_DESEL && !drv));

    assert_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && !ce_n && &bw_n) |=> (mode_q == SB_READ && (drv || oe_n)));

    assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && !ce_n && !(&bw_n)) |=> (mode_q == SB_WRITE));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ads_n |=> $stable(held_addr));

    assert_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_n && mode_q == SB_DESEL) |=> (mode_q == SB_DESEL));

    assert_nodrive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SB_WRITE) |-> !drv);

    always_comb begin
        if (rst_n && oe_n) begin
            assert_oe_R9: assert (!drv);
        end
    end
endmodule

bind sync_bw_sram sbw_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .ce_n(ce_n), .bw_n(bw_n),
    .oe_n(oe_n), .mode_q(mode_q), .held_addr(held_addr), .drv(bus_drv)
);

// File: tb/sync_bw_sram_test.sv
`timescale 1ns/1ps
module sync_bw_sram_test;
    localparam int AW  = 19;
    localparam int LN  = 8;
    localparam int LW  = 8;
    localparam int DEP = 256;
    localparam int DW  = LN * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [AW-1:0] addr  = '0;
    logic          ads_n = 1'b1;
    logic          ce_n  = 1'b1;
    logic          oe_n  = 1'b1;
    logic [LN-1:0] bw_n  = '1;
    wire  [DW-1:0] dq;
    wire  [LN-1:0] dp;
    logic [DW-1:0] tb_dq  = '0;
    logic [LN-1:0] tb_dp  = '0;
    logic          tb_den = 1'b0;

    assign dq = tb_den ? tb_dq : {DW{1'bz}};
    assign dp = tb_den ? tb_dp : {LN{1'bz}};

    // a released bus reads as zero; written data never has an all-zero lane
    for (genvar i = 0; i < DW; i++) begin : g_pd_dq
        pulldown (dq[i]);
    end
    for (genvar i = 0; i < LN; i++) begin : g_pd_dp
        pulldown (dp[i]);
    end

    sync_bw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ads_n(ads_n), .ce_n(ce_n),
        .bw_n(bw_n), .oe_n(oe_n), .dq(dq), .dp(dp)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // shadow memory kept from the requirements
    logic [LW:0] sh [DEP][LN];
    bit          kn [DEP][LN];
    int          m_mode = 0;   // 0 deselected, 1 read, 2 write
    int          m_held = 0;

    function automatic logic [LW-1:0] lane_byte(logic [7:0] s, int l);
        return s ^ 8'(l * 29);
    endfunction

    function automatic logic lane_par(logic [7:0] s, int l);
        return s[l] ^ l[0];
    endfunction

    task automatic chk(bit ok, string req, string act, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic check_z(string req);
        chk(dq == '0 && dp == '0, req, $sformatf("dq=%h dp=%h", dq, dp),
            "bus released");
    endtask

    task automatic check_read(int a, string req);
        logic [DW-1:0] e_dq, m_dq;
        logic [LN-1:0] e_dp, m_dp;
        e_dq = '0; m_dq = '0; e_dp = '0; m_dp = '0;
        for (int l = 0; l < LN; l++) begin
            if (kn[a][l]) begin
                e_dq[l*LW +: LW] = sh[a][l][LW-1:0];
                m_dq[l*LW +: LW] = '1;
                e_dp[l] = sh[a][l][LW];
                m_dp[l] = 1'b1;
            end
        end
        chk(m_dq != '0 && ((dq ^ e_dq) & m_dq) == '0 && ((dp ^ e_dp) & m_dp) == '0,
            req, $sformatf("dq=%h dp=%h", dq & m_dq, dp & m_dp),
            $sformatf("dq=%h dp=%h", e_dq, e_dp));
    endtask

    typedef struct packed {
        logic          ads;
        logic          ce;
        logic [LN-1:0] bw;
        logic          oe;
        logic [AW-1:0] a;
        logic [7:0]    s;
        logic          ed;    // expected: 1 device drives, 0 bus released
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'hFF, 1'b0, 19'd5,   8'h00, 1'b0, 4'd6},  // R6 idle after reset
        '{1'b0, 1'b0, 8'h00, 1'b1, 19'd10,  8'h11, 1'b0, 4'd4},  // R4 full write
        '{1'b1, 1'b1, 8'h00, 1'b1, 19'd99,  8'h22, 1'b0, 4'd5},  // R5 write to held addr
        '{1'b0, 1'b0, 8'hFF, 1'b0, 19'd10,  8'h00, 1'b1, 4'd3},  // R3 read, R8 parity
        '{1'b1, 1'b1, 8'hFF, 1'b0, 19'd77,  8'h00, 1'b1, 4'd5},  // R5 read held addr
        '{1'b1, 1'b0, 8'hFF, 1'b1, 19'd0,   8'h00, 1'b0, 4'd9},  // R9 oe high
        '{1'b0, 1'b0, 8'hA5, 1'b1, 19'd10,  8'h33, 1'b0, 4'd7},  // R7 partial write
        '{1'b0, 1'b0, 8'h00, 1'b0, 19'd20,  8'h44, 1'b0, 4'd10}, // R10 write, oe low
        '{1'b0, 1'b0, 8'hFF, 1'b0, 19'd10,  8'h00, 1'b1, 4'd7},  // R7 mixed lanes
        '{1'b1, 1'b0, 8'hFF, 1'b1, 19'd0,   8'h00, 1'b0, 4'd9},  // R9
        '{1'b0, 1'b1, 8'h00, 1'b1, 19'd10,  8'h55, 1'b0, 4'd2},  // R2 deselect
        '{1'b1, 1'b0, 8'h00, 1'b1, 19'd10,  8'h66, 1'b0, 4'd6},  // R6 no write
        '{1'b0, 1'b0, 8'hFF, 1'b0, 19'd10,  8'h00, 1'b1, 4'd6},  // R6 contents kept
        '{1'b1, 1'b0, 8'hFF, 1'b1, 19'd0,   8'h00, 1'b0, 4'd9},  // R9
        '{1'b0, 1'b0, 8'hFF, 1'b0, 19'd20,  8'h00, 1'b1, 4'd10}, // R10 data written
        '{1'b1, 1'b0, 8'hFF, 1'b1, 19'd0,   8'h00, 1'b0, 4'd9},  // R9
        '{1'b0, 1'b0, 8'h7F, 1'b1, 19'd255, 8'h77, 1'b0, 4'd7},  // R7 top lane only
        '{1'b1, 1'b1, 8'h80, 1'b1, 19'd3,   8'h88, 1'b0, 4'd7},  // R7 other lanes, held
        '{1'b0, 1'b0, 8'hFF, 1'b0, 19'd255, 8'h00, 1'b1, 4'd8}   // R8 parity per lane
    };

    initial begin
        for (int a = 0; a < DEP; a++)
            for (int l = 0; l < LN; l++) kn[a][l] = 1'b0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2 check_z("R1 during reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #2 check_z("R1 after reset");

        foreach (VEC[i]) begin
            @(negedge clk);
            ads_n = VEC[i].ads;
            ce_n  = VEC[i].ce;
            bw_n  = VEC[i].bw;
            oe_n  = VEC[i].oe;
            addr  = VEC[i].a;
            if (VEC[i].bw != '1) begin
                for (int l = 0; l < LN; l++) begin
                    tb_dq[l*LW +: LW] = lane_byte(VEC[i].s, l);
                    tb_dp[l]          = lane_par(VEC[i].s, l);
                end
                tb_den = 1'b1;
            end
            if (!VEC[i].ads) begin
                if (VEC[i].ce) m_mode = 0;
                else begin
                    m_held = int'(VEC[i].a) % DEP;
                    m_mode = (VEC[i].bw != '1) ? 2 : 1;
                end
            end else if (m_mode != 0) begin
                m_mode = (VEC[i].bw != '1) ? 2 : 1;
            end
            if (m_mode == 2) begin
                for (int l = 0; l < LN; l++) begin
                    if (!VEC[i].bw[l]) begin
                        sh[m_held][l] = {lane_par(VEC[i].s, l), lane_byte(VEC[i].s, l)};
                        kn[m_held][l] = 1'b1;
                    end
                end
            end
            @(posedge clk);
            #1 tb_den = 1'b0;
            #1;
            if (VEC[i].ed) check_read(m_held, $sformatf("R%0d vec %0d", VEC[i].req, i));
            else           check_z($sformatf("R%0d vec %0d", VEC[i].req, i));
        end

        // R9: output enable acts between clock edges during the last read
        oe_n = 1'b1;
        #0.5 check_z("R9 release without edge");
        oe_n = 1'b0;
        #0.5 check_read(255, "R9 drive without edge");

        // R1: reset in mid-read releases the bus at once
        @(negedge clk);
        rst_n = 1'b0;
        #1 check_z("R1 reset during read");
        @(negedge clk) rst_n = 1'b1;
        ads_n = 1'b1;
        bw_n  = '1;
        @(posedge clk);
        #2 check_z("R1 idle after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule